// File: doc/BRIEF.md
# Per-Channel Event Sense Interrupt Unit

This block watches a set of digital input channels and latches a status bit whenever a channel shows the transition it was configured for. Each channel picks its own trigger: a drop from high to low, a rise from low to high, or any change of level. An optional per-channel debounce filter can stand in front of the detector, so that a new level only counts once it has held for a programmable number of sample ticks. Latched events stay pending until software clears them by writing ones. Any pending event on a channel whose interrupt is enabled pulls a single active-low interrupt line, provided the global interrupt enable is set.

All of this is active only while the enhanced-mode input is high. In standard mode the inputs are passed through unfiltered and no events are recorded. Configuration is held in byte-wide registers on a simple write strobe and address. Reads come back combinationally on the same address. During an interrupt acknowledge the read byte carries a stored 8-bit vector instead.

Top module: `evt_sense_irq`

## Requirements
- R1: After reset every register reads 0x00, no event is pending and irq_n is high.
- R2: A channel with its any-change bit (bytes 0x04-0x07) clear and its rise bit (bytes 0x00-0x03) clear records a high-to-low change of its level and ignores a low-to-high change. Channel i sits at bit i%8 of byte base+i/8. With debounce off, an input change applied before clock edge k sets the status bit at edge k+1.
- R3: A channel with its any-change bit clear and its rise bit set records only a low-to-high change.
- R4: A channel with its any-change bit set records every level change, whatever its rise bit holds.
- R5: Status bits (bytes 0x08-0x0B) are sticky. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and an event in the same cycle as a clear leaves the bit set.
- R6: irq_n goes low one clock after a cycle in which enhanced mode is on, control bit 0 (address 0x14) is set, and some status bit has its interrupt enable bit (bytes 0x0C-0x0F) set. Otherwise irq_n is high.
- R7: While iack is high, rd_data carries the vector register (address 0x15) whatever the address.
- R8: With a channel's debounce bit (bytes 0x10-0x13) set, a new input level is accepted only after it has differed from the accepted level on THR consecutive sample ticks. THR is address 0x16, and 0 counts as 1. A tick occurs every TICK_DIV clocks. A shorter excursion records nothing.
- R9: With enhanced mode off, no status bit is set, debounce is bypassed and irq_n stays high.
- R10: Every register listed above reads back the value last written, with the exception of the write-1-to-clear status bytes. Unlisted addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enh_mode | input | 1 | Enables event sensing, debounce and interrupts |
| chan_in | input | 32 | Channel input levels |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte address for writes and reads |
| wr_data | input | 8 | Write data byte |
| iack | input | 1 | Interrupt acknowledge; selects the vector onto rd_data |
| rd_data | output | 8 | Read data byte (combinational) |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The checker enforces several rules on every cycle. Status bits never drop without a write-1-to-clear to their byte. No new status bit appears in standard mode. irq_n stays high whenever the global enable or enhanced mode was off in the previous cycle, and it only falls after an enabled pending bit. The vector appears during acknowledge. Whether the right transition type was caught, whether debounce rejects short pulses and accepts long ones after the exact tick count, and the read-back map can only be shown by the bench's scenarios against its reference model.

// File: rtl/evt_sense_pkg.sv
package evt_sense_pkg;
    localparam int NCH      = 32;
    localparam int NBYTE    = NCH / 8;
    localparam int ADDR_W   = 5;
    localparam int THR_W    = 8;
    localparam int RISE_BASE = 'h00;
    localparam int COS_BASE  = 'h04;
    localparam int STAT_BASE = 'h08;
    localparam int IEN_BASE  = 'h0C;
    localparam int DEB_BASE  = 'h10;
    localparam int CTRL_ADDR = 'h14;
    localparam int VEC_ADDR  = 'h15;
    localparam int THR_ADDR  = 'h16;

    typedef struct packed {
        logic [NCH-1:0]   rise;
        logic [NCH-1:0]   cos;
        logic [NCH-1:0]   status;
        logic [NCH-1:0]   ien;
        logic [NCH-1:0]   deb_en;
        logic             glob_en;
        logic [7:0]       vec;
        logic [THR_W-1:0] thr;
        logic [NCH-1:0]   raw;
        logic [NCH-1:0]   prev;
        logic             irq_n;
    } evt_regs_t;
endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/evt_debounce.sv
module evt_debounce #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          tick,
    input  logic          raw,
    input  logic [CW-1:0] thr,
    output logic          lvl
);
    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t s_d, s_q;
    logic [CW:0] need;

    always_comb begin
        s_d  = s_q;
        need = (thr == '0) ? (CW+1)'(1) : {1'b0, thr};
        if (!active) begin
            s_d.lvl = raw;
            s_d.cnt = '0;
        end else if (raw == s_q.lvl) begin
            s_d.cnt = '0;
        end else if (tick) begin
            if (({1'b0, s_q.cnt} + 1'b1) >= need) begin
                s_d.lvl = raw;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign lvl = s_q.lvl;
endmodule

// File: rtl/evt_sense_irq.sv
module evt_sense_irq
    import evt_sense_pkg::*;
#(
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_mode,
    input  logic [NCH-1:0]    chan_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              iack,
    output logic [7:0]        rd_data,
    output logic              irq_n
);
    evt_regs_t r_d, r_q;
    logic             tick;
    logic [NCH-1:0]   deb_lvl;
    logic [NCH-1:0]   lvl;
    logic [NCH-1:0]   evt;
    logic [NCH-1:0]   clr;

    evt_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        evt_debounce #(.CW(THR_W)) deb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .active(enh_mode & r_q.deb_en[i]),
            .tick  (tick),
            .raw   (r_q.raw[i]),
            .thr   (r_q.thr),
            .lvl   (deb_lvl[i])
        );
        assign lvl[i] = (enh_mode && r_q.deb_en[i]) ? deb_lvl[i] : r_q.raw[i];
        assign evt[i] = enh_mode && (lvl[i] != r_q.prev[i]) &&
                        (r_q.cos[i] || (r_q.rise[i] ? lvl[i] : !lvl[i]));
    end

    always_comb begin
        r_d = r_q;
        clr = '0;
        if (wr_en) begin
            for (int b = 0; b < NBYTE; b++) begin
                if (addr == ADDR_W'(RISE_BASE + b)) r_d.rise[b*8 +: 8]   = wr_data;
                if (addr == ADDR_W'(COS_BASE + b))  r_d.cos[b*8 +: 8]    = wr_data;
                if (addr == ADDR_W'(IEN_BASE + b))  r_d.ien[b*8 +: 8]    = wr_data;
                if (addr == ADDR_W'(DEB_BASE + b))  r_d.deb_en[b*8 +: 8] = wr_data;
                if (addr == ADDR_W'(STAT_BASE + b)) clr[b*8 +: 8]        = wr_data;
            end
            if (addr == ADDR_W'(CTRL_ADDR)) r_d.glob_en = wr_data[0];
            if (addr == ADDR_W'(VEC_ADDR))  r_d.vec     = wr_data;
            if (addr == ADDR_W'(THR_ADDR))  r_d.thr     = wr_data[THR_W-1:0];
        end
        r_d.status = (r_q.status & ~clr) | evt;
        r_d.raw    = chan_in;
        r_d.prev   = lvl;
        r_d.irq_n  = !(r_q.glob_en && enh_mode && |(r_q.status & r_q.ien));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.irq_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        for (int b = 0; b < NBYTE; b++) begin
            if (addr == ADDR_W'(RISE_BASE + b)) rd_data = r_q.rise[b*8 +: 8];
            if (addr == ADDR_W'(COS_BASE + b))  rd_data = r_q.cos[b*8 +: 8];
            if (addr == ADDR_W'(STAT_BASE + b)) rd_data = r_q.status[b*8 +: 8];
            if (addr == ADDR_W'(IEN_BASE + b))  rd_data = r_q.ien[b*8 +: 8];
            if (addr == ADDR_W'(DEB_BASE + b))  rd_data = r_q.deb_en[b*8 +: 8];
        end
        if (addr == ADDR_W'(CTRL_ADDR)) rd_data = {7'b0, r_q.glob_en};
        if (addr == ADDR_W'(VEC_ADDR))  rd_data = r_q.vec;
        if (addr == ADDR_W'(THR_ADDR))  rd_data = 8'(r_q.thr);
        if (iack) rd_data = r_q.vec;
    end

    assign irq_n = r_q.irq_n;

    logic [NCH-1:0] stat_vis, ien_vis;
    logic           gen_vis;
    logic [7:0]     vec_vis;
    assign stat_vis = r_q.status;
    assign ien_vis  = r_q.ien;
    assign gen_vis  = r_q.glob_en;
    assign vec_vis  = r_q.vec;
endmodule

// File: rtl/evt_sense_irq_chk.sv
module evt_sense_irq_chk
    import evt_sense_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enh_mode,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              iack,
    input logic [7:0]        rd_data,
    input logic              irq_n,
    input logic [NCH-1:0]    stat,
    input logic [NCH-1:0]    ien,
    input logic              gen,
    input logic [7:0]        vec
);
    logic stat_wr;
    assign stat_wr = wr_en && (addr >= ADDR_W'(STAT_BASE)) && (addr < ADDR_W'(STAT_BASE + NBYTE));

    // R5
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_wr) |-> (($past(stat) & ~stat) == '0));

    // R9
    std_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enh_mode) |-> ((stat & ~$past(stat)) == '0) && irq_n);

    // R6
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gen) |-> irq_n);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> $past(|(stat & ien)));

    // R7
    ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iack |-> (rd_data == vec));
endmodule

bind evt_sense_irq evt_sense_irq_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enh_mode(enh_mode),
    .wr_en   (wr_en),
    .addr    (addr),
    .iack    (iack),
    .rd_data (rd_data),
    .irq_n   (irq_n),
    .stat    (stat_vis),
    .ien     (ien_vis),
    .gen     (gen_vis),
    .vec     (vec_vis)
);

// File: tb/evt_sense_irq_tb_top.sv
module evt_sense_irq_tb_top;
    localparam int N   = 32;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enh_mode = 1'b0;
    logic [N-1:0] chan_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic        iack = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_n;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2ns clk = ~clk;

    evt_sense_irq #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .chan_in(chan_in),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .iack(iack),
        .rd_data(rd_data), .irq_n(irq_n)
    );

    // behavioural reference model
    bit [N-1:0] m_rise, m_cos, m_stat, m_ien, m_deb, m_raw, m_prev, m_dl;
    int         m_cnt [N];
    bit         m_gen, m_irqn;
    int         m_vec, m_thr, m_div;

    function automatic int exp_rd(int a);
        if (iack) return m_vec;
        if (a < 4)        return int'(m_rise[a*8 +: 8]);
        if (a < 8)        return int'(m_cos[(a-4)*8 +: 8]);
        if (a < 12)       return int'(m_stat[(a-8)*8 +: 8]);
        if (a < 16)       return int'(m_ien[(a-12)*8 +: 8]);
        if (a < 20)       return int'(m_deb[(a-16)*8 +: 8]);
        if (a == 20)      return int'(m_gen);
        if (a == 21)      return m_vec;
        if (a == 22)      return m_thr;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rise = '0; m_cos = '0; m_stat = '0; m_ien = '0; m_deb = '0;
            m_raw = '0; m_prev = '0; m_dl = '0; m_gen = 0; m_irqn = 1;
            m_vec = 0; m_thr = 0; m_div = 0;
            for (int i = 0; i < N; i++) m_cnt[i] = 0;
        end else begin
            bit [N-1:0] lv, ev, clrm;
            bit tk;
            int need;
            tk = (m_div == DIV - 1);
            need = (m_thr == 0) ? 1 : m_thr;
            ev = '0; clrm = '0;
            for (int i = 0; i < N; i++) begin
                bit use_deb;
                use_deb = enh_mode && m_deb[i];
                lv[i] = use_deb ? m_dl[i] : m_raw[i];
                if (enh_mode && lv[i] != m_prev[i]) begin
                    if (m_cos[i]) ev[i] = 1;
                    else if (m_rise[i] && lv[i]) ev[i] = 1;
                    else if (!m_rise[i] && !lv[i]) ev[i] = 1;
                end
                if (!use_deb) begin
                    m_dl[i] = m_raw[i]; m_cnt[i] = 0;
                end else if (m_raw[i] == m_dl[i]) begin
                    m_cnt[i] = 0;
                end else if (tk) begin
                    if (m_cnt[i] + 1 >= need) begin
                        m_dl[i] = m_raw[i]; m_cnt[i] = 0;
                    end else m_cnt[i]++;
                end
            end
            m_irqn = !(m_gen && enh_mode && ((m_stat & m_ien) != 0));
            if (wr_en) begin
                int a;
                a = int'(addr);
                if (a < 4)       m_rise[a*8 +: 8] = wr_data;
                else if (a < 8)  m_cos[(a-4)*8 +: 8] = wr_data;
                else if (a < 12) clrm[(a-8)*8 +: 8] = wr_data;
                else if (a < 16) m_ien[(a-12)*8 +: 8] = wr_data;
                else if (a < 20) m_deb[(a-16)*8 +: 8] = wr_data;
                else if (a == 20) m_gen = wr_data[0];
                else if (a == 21) m_vec = int'(wr_data);
                else if (a == 22) m_thr = int'(wr_data);
            end
            m_stat = (m_stat & ~clrm) | ev;
            m_prev = lv;
            m_raw  = chan_in;
            m_div  = tk ? 0 : m_div + 1;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1ns;
        if (rst_n && !done) begin
            chk(irq_n == m_irqn, "R6 irq_n vs model", int'(irq_n), int'(m_irqn));
            chk(int'(rd_data) == exp_rd(int'(addr)), iack ? "R7 vector" : "R10 read vs model",
                int'(rd_data), exp_rd(int'(addr)));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1; addr = 5'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd_chk(int a, int exp, string tag);
        @(negedge clk);
        addr = 5'(a);
        #1ns;
        chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
    endtask

    initial begin
        #400us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(4);
        rst_n = 1;
        // R1 reset state
        rd_chk(8'h08, 0, "R1 status byte0 after reset");
        rd_chk(8'h14, 0, "R1 ctrl after reset");
        chk(irq_n == 1, "R1 irq_n after reset", int'(irq_n), 1);
        rd_chk(8'h1F, 0, "R10 unmapped address");

        enh_mode = 1;
        wr(8'h00, 8'h0F);  // ch0-3 rise, ch4-7 fall
        wr(8'h05, 8'hFF);  // ch8-15 any change
        wr(8'h0C, 8'hFF);
        wr(8'h14, 8'h01);
        wr(8'h15, 8'hA5);
        rd_chk(8'h00, 8'h0F, "R10 rise byte0 readback");

        // R3 rising edge on ch0
        @(negedge clk) chan_in[0] = 1;
        cyc(3);
        rd_chk(8'h08, 8'h01, "R3 rise on ch0 recorded");
        // R2 fall-type channel ignores a rise
        @(negedge clk) chan_in[4] = 1;
        cyc(3);
        rd_chk(8'h08, 8'h01, "R2 rise ignored on ch4");
        @(negedge clk) chan_in[4] = 0;
        cyc(3);
        rd_chk(8'h08, 8'h11, "R2 fall recorded on ch4");
        // R3 falling ignored on rise-type channel
        @(negedge clk) chan_in[0] = 0;
        cyc(3);
        rd_chk(8'h08, 8'h11, "R3 fall ignored on ch0");
        // R6 irq low
        cyc(1);
        chk(irq_n == 0, "R6 irq asserted", int'(irq_n), 0);
        // R7 vector on acknowledge
        @(negedge clk) begin iack = 1; addr = 5'h02; end
        #1ns chk(int'(rd_data) == 8'hA5, "R7 vector on iack", int'(rd_data), 8'hA5);
        @(negedge clk) iack = 0;
        // R5 W1C clears only written bits
        wr(8'h08, 8'h01);
        rd_chk(8'h08, 8'h10, "R5 W1C clears bit0 keeps bit4");
        // R4 change of state on ch8 both directions
        @(negedge clk) chan_in[8] = 1;
        cyc(3);
        rd_chk(8'h09, 8'h01, "R4 rise on cos channel");
        wr(8'h09, 8'h01);
        @(negedge clk) chan_in[8] = 0;
        cyc(3);
        rd_chk(8'h09, 8'h01, "R4 fall on cos channel");
        // R5 set wins over simultaneous clear: ch9 change at same edge as clear
        @(negedge clk) chan_in[9] = 1;
        @(negedge clk) begin wr_en = 1; addr = 5'h09; wr_data = 8'h02; end
        @(negedge clk) wr_en = 0;
        rd_chk(8'h09, 8'h03, "R5 event beats clear");
        wr(8'h09, 8'hFF);
        wr(8'h08, 8'hFF);
        // R6 global enable off
        wr(8'h14, 8'h00);
        cyc(2);
        chk(irq_n == 1, "R6 irq high with enable off", int'(irq_n), 1);

        // R8 debounce on byte2 (ch16-23), rise type, THR=3
        wr(8'h02, 8'hFF);
        wr(8'h12, 8'hFF);
        wr(8'h16, 8'h03);
        cyc(2);
        @(negedge clk) chan_in[16] = 1;
        cyc(2);
        @(negedge clk) chan_in[16] = 0;
        cyc(20);
        rd_chk(8'h0A, 8'h00, "R8 short pulse rejected");
        @(negedge clk) chan_in[16] = 1;
        cyc(6);
        rd_chk(8'h0A, 8'h00, "R8 not yet accepted");
        cyc(14);
        rd_chk(8'h0A, 8'h01, "R8 long pulse accepted");

        // R9 standard mode
        wr(8'h0A, 8'hFF);
        wr(8'h14, 8'h01);
        enh_mode = 0;
        @(negedge clk) chan_in[12] = 1;
        cyc(4);
        rd_chk(8'h09, 8'h00, "R9 no event in standard mode");
        chk(irq_n == 1, "R9 irq high in standard mode", int'(irq_n), 1);
        enh_mode = 1;
        cyc(4);

        // mixed random traffic checked against the model every clock
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            wr_en = 0;
            iack  = ($urandom_range(0, 15) == 0);
            addr  = 5'($urandom_range(0, 23));
            if ($urandom_range(0, 7) == 0) chan_in = chan_in ^ (32'(1) << $urandom_range(0, 31));
            if ($urandom_range(0, 9) == 0) begin
                wr_en = 1; wr_data = 8'($urandom);
            end
            if ($urandom_range(0, 199) == 0) enh_mode = ~enh_mode;
        end
        @(negedge clk) begin wr_en = 0; iack = 0; end
        cyc(2);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule